// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block sits on the controller side of a synchronous DRAM interface. It owns the command bus from reset until the memory is ready for normal traffic. While it runs, it walks the memory through the start-up steps in a fixed order:

- It holds a quiet bus long enough for supply and clock to settle.
- It closes every bank.
- It issues a burst of auto-refresh commands.
- It programs the mode word.
- After the last recovery wait, it raises a ready level and a one-cycle done pulse for the controller that takes over.

Every bus pin leaves the block from a register. Each wait length is a parameter. The power-settle wait is derived from the clock period and the required settle time in nanoseconds. The other recovery times (precharge, refresh-to-refresh, mode-set) and the refresh count are given directly in cycles. The mode word is also set by parameters: burst length, burst type, CAS latency and write mode. Each command lasts exactly one cycle, and NOPs fill every other cycle.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, the bus carries a NOP (chip select 0, RAS/CAS/WE = 1/1/1), CKE is 1, every DQM bit is 1, and ready and done are 0. The DQM bits stay 1 until ready rises.
- R2: Counting rising edges after reset falls as edge 1, 2, …, the first non-NOP command appears after edge P = ceil(POWERUP_NS·1000 / CLK_PERIOD_PS). It is a precharge-all: RAS/CAS/WE = 0/1/0, with address bit 10 = 1 and bank = 0. Every cycle before it is a NOP.
- R3: The first auto-refresh (RAS/CAS/WE = 0/0/1) appears TRP_CYC edges after the precharge.
- R4: Exactly REFRESH_CNT auto-refreshes are issued, each TRC_CYC edges after the previous one, with only NOPs in between.
- R5: The mode-register set (RAS/CAS/WE = 0/0/0) appears TRC_CYC edges after the last refresh.
- R6: During the mode-register set, the address carries burst length in [2:0], burst type in [3], CAS latency in [6:4] and write mode in [9]. Bits [8:7] and every bit above 9 are 0, and the bank is 0.
- R7: Ready and done rise TRSC_CYC edges after the mode-register set. Done is high for exactly one cycle. Ready stays high until the next reset. DQM drops to 0 in the cycle ready rises.
- R8: Once ready is high, the bus carries only NOPs.
- R9: A reset at any point restarts the whole sequence, including the full power-settle wait.
- R10: CKE is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Address / mode word |
| dqm_o | output | DQM_W | Data mask, all high until ready |
| init_done_o | output | 1 | One-cycle pulse when start-up completes |
| ready_o | output | 1 | High from start-up completion until reset |

## Verification
The bench compares the bus trace cycle by cycle against a schedule it computes from the parameters.

A full uninterrupted run checks that each command lands on exactly its edge and that no command appears between steps. It also checks that ready holds afterwards.

Resets are also applied at random points with a fixed seed, including inside refresh spacing and after ready. These runs show whether every counter and the refresh tally restart, or whether leftover state shortens the power-settle wait.

Directed cases cut the sequence one cycle before the precharge and exactly at the mode set. These separate an off-by-one in the first wait from one in the final wait.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [1:0] {
    CMD_NOP       = 2'd0,
    CMD_PRECHARGE = 2'd1,
    CMD_REFRESH   = 2'd2,
    CMD_LOADMODE  = 2'd3
  } sd_cmd_e;

  typedef enum logic [2:0] {
    PH_POWERUP,
    PH_PRE_WAIT,
    PH_REF_WAIT,
    PH_MODE_WAIT,
    PH_RUN
  } init_phase_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_strobe_t;

  function automatic sd_strobe_t strobes_of(sd_cmd_e c);
    sd_strobe_t s;
    case (c)
      CMD_PRECHARGE: s = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REFRESH:   s = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_LOADMODE:  s = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:       s = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return s;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdinit_countdown.sv
module sdinit_countdown #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= RST_VAL;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);

  // An exhausted counter never wraps back up on its own.
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (zero_o && !load) |=> zero_o); // R4

  // Without a load, the count never grows.
  AST_CNT_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero_o) |=> (cnt <= $past(cnt))); // R9

endmodule

// File: rtl/sdinit_bus_drive.sv
module sdinit_bus_drive
  import sdinit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           cmd,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] ba_o
);

  localparam int AP_BIT = 10;
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  sd_strobe_t               strobe_nx;
  logic [ADDR_W-1:0]        addr_nx;

  always_comb begin
    strobe_nx = strobes_of(cmd);
    case (cmd)
      CMD_PRECHARGE: addr_nx = ALL_BANKS;
      CMD_LOADMODE:  addr_nx = mode_word;
      default:       addr_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_o  <= 1'b0;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      addr_o  <= '0;
      ba_o    <= '0;
    end else begin
      cs_n_o  <= 1'b0;
      ras_n_o <= strobe_nx.ras_n;
      cas_n_o <= strobe_nx.cas_n;
      we_n_o  <= strobe_nx.we_n;
      addr_o  <= addr_nx;
      ba_o    <= '0;
    end
  end

  AST_PRE_ALL_BIT: assert property (@(posedge clk) disable iff (rst)
    (!ras_n_o && cas_n_o && !we_n_o) |-> addr_o[AP_BIT]); // R2

  AST_MODE_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!ras_n_o && !cas_n_o && !we_n_o) |-> (ba_o == '0) && (addr_o[8:7] == 2'b00)); // R6

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int          CLK_PERIOD_PS   = 7500,
  parameter int          POWERUP_NS      = 200000,
  parameter int          TRP_CYC         = 3,
  parameter int          TRC_CYC         = 9,
  parameter int          TRSC_CYC        = 2,
  parameter int          REFRESH_CNT     = 8,
  parameter int          ADDR_W          = 12,
  parameter int          BANK_W          = 2,
  parameter int          DQM_W           = 8,
  parameter logic [2:0]  MR_BURST_LEN    = 3'b011,
  parameter logic        MR_BURST_TYPE   = 1'b0,
  parameter logic [2:0]  MR_CAS_LAT      = 3'b011,
  parameter logic        MR_WRITE_SINGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              init_done_o,
  output logic              ready_o
);

  // Power-settle wait in cycles, rounded up.
  localparam int PWR_CYC  = (POWERUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MAX_WAIT = max_of(max_of(PWR_CYC, TRC_CYC), max_of(TRP_CYC, TRSC_CYC));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(REFRESH_CNT + 1);

  localparam logic [CNT_W-1:0] LD_PWR  = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TRP  = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TRC  = CNT_W'(TRC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TRSC = CNT_W'(TRSC_CYC - 1);
  localparam logic [REF_W-1:0] REF_RST = REF_W'(REFRESH_CNT);

  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({MR_WRITE_SINGLE, 2'b00, MR_CAS_LAT, MR_BURST_TYPE, MR_BURST_LEN});

  init_phase_e       phase, phase_nx;
  sd_cmd_e           cmd_nx;
  logic              wait_load;
  logic [CNT_W-1:0]  wait_val;
  logic              wait_zero;
  logic              ref_dec;
  logic              ref_zero;
  logic              ready_set;

  sdinit_countdown #(.W(CNT_W), .RST_VAL(LD_PWR)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (wait_load),
    .load_val (wait_val),
    .dec      (1'b1),
    .zero_o   (wait_zero)
  );

  sdinit_countdown #(.W(REF_W), .RST_VAL(REF_RST)) u_refs (
    .clk      (clk),
    .rst      (rst),
    .load     (1'b0),
    .load_val ('0),
    .dec      (ref_dec),
    .zero_o   (ref_zero)
  );

  always_comb begin
    phase_nx  = phase;
    cmd_nx    = CMD_NOP;
    wait_load = 1'b0;
    wait_val  = '0;
    ref_dec   = 1'b0;
    ready_set = 1'b0;
    case (phase)
      PH_POWERUP: if (wait_zero) begin
        cmd_nx    = CMD_PRECHARGE;
        wait_load = 1'b1;
        wait_val  = LD_TRP;
        phase_nx  = PH_PRE_WAIT;
      end
      PH_PRE_WAIT: if (wait_zero) begin
        cmd_nx    = CMD_REFRESH;
        wait_load = 1'b1;
        wait_val  = LD_TRC;
        ref_dec   = 1'b1;
        phase_nx  = PH_REF_WAIT;
      end
      PH_REF_WAIT: if (wait_zero) begin
        wait_load = 1'b1;
        if (ref_zero) begin
          cmd_nx   = CMD_LOADMODE;
          wait_val = LD_TRSC;
          phase_nx = PH_MODE_WAIT;
        end else begin
          cmd_nx   = CMD_REFRESH;
          wait_val = LD_TRC;
          ref_dec  = 1'b1;
        end
      end
      PH_MODE_WAIT: if (wait_zero) begin
        ready_set = 1'b1;
        phase_nx  = PH_RUN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_POWERUP;
      ready_o     <= 1'b0;
      init_done_o <= 1'b0;
      dqm_o       <= '1;
      cke_o       <= 1'b1;
    end else begin
      phase       <= phase_nx;
      init_done_o <= ready_set;
      cke_o       <= 1'b1;
      if (ready_set) begin
        ready_o <= 1'b1;
        dqm_o   <= '0;
      end
    end
  end

  sdinit_bus_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_nx),
    .mode_word (MODE_WORD),
    .cs_n_o    (cs_n_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .addr_o    (addr_o),
    .ba_o      (ba_o)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    init_done_o |=> !init_done_o); // R7

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o); // R7

  AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> init_done_o); // R7

  AST_MASK_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (&dqm_o)); // R1

  AST_QUIET_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!cs_n_o && ras_n_o && cas_n_o && we_n_o)); // R8

  AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !(ras_n_o && cas_n_o && we_n_o) |=> (ras_n_o && cas_n_o && we_n_o)); // R4

  AST_CKE_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(cke_o) |-> cke_o); // R10

endmodule

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

  localparam int TB_PERIOD_PS = 20000;
  localparam int TB_PWR_NS    = 2000;
  localparam int TB_TRP       = 3;
  localparam int TB_TRC       = 9;
  localparam int TB_TRSC      = 2;
  localparam int TB_REFS      = 8;

  localparam int E_PRE  = (TB_PWR_NS * 1000 + TB_PERIOD_PS - 1) / TB_PERIOD_PS;
  localparam int E_REF0 = E_PRE + TB_TRP;
  localparam int E_MRS  = E_REF0 + TB_REFS * TB_TRC;
  localparam int E_RDY  = E_MRS + TB_TRSC;
  // burst len 3'b010, type 1, CAS 3'b011, write mode 1
  localparam int EXP_MODE = (1 << 9) | (3 << 4) | (1 << 3) | 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, done, ready;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [7:0]  dqm;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .CLK_PERIOD_PS(TB_PERIOD_PS), .POWERUP_NS(TB_PWR_NS),
    .TRP_CYC(TB_TRP), .TRC_CYC(TB_TRC), .TRSC_CYC(TB_TRSC),
    .REFRESH_CNT(TB_REFS), .ADDR_W(12), .BANK_W(2), .DQM_W(8),
    .MR_BURST_LEN(3'b010), .MR_BURST_TYPE(1'b1),
    .MR_CAS_LAT(3'b011), .MR_WRITE_SINGLE(1'b1)
  ) dut_i (
    .clk(clk), .rst(rst), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .dqm_o(dqm),
    .init_done_o(done), .ready_o(ready)
  );

  // 0 NOP, 1 precharge, 2 refresh, 3 mode set, 4 deselect, 7 other
  function automatic int bus_code();
    if (cs_n) return 4;
    case ({ras_n, cas_n, we_n})
      3'b111:  return 0;
      3'b010:  return 1;
      3'b001:  return 2;
      3'b000:  return 3;
      default: return 7;
    endcase
  endfunction

  function automatic int exp_code(int k);
    if (k == E_PRE) return 1;
    if (k >= E_REF0 && k < E_MRS && ((k - E_REF0) % TB_TRC) == 0) return 2;
    if (k == E_MRS) return 3;
    return 0;
  endfunction

  function automatic string req_of(int k);
    if (k <= E_PRE) return "R2";
    if (k == E_REF0) return "R3";
    if (k < E_MRS) return "R4";
    if (k == E_MRS) return "R5";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(bus_code() == 0, "R1 bus", bus_code(), 0);
      chk(cke && (&dqm), "R1 cke/dqm", {cke, dqm}, 9'h1ff);
      chk(!ready && !done, "R1 flags", {ready, done}, 0);
    end
    rst = 1'b0;
  endtask

  task automatic run_seq(input int last, input bit restarted);
    for (int k = 1; k <= last; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(bus_code() == exp_code(k), req_of(k), bus_code(), exp_code(k));
      chk(cke == 1'b1, "R10", cke, 1);
      chk(ready == (k >= E_RDY), "R7 ready", ready, k >= E_RDY);
      chk(done == (k == E_RDY), "R7 done", done, k == E_RDY);
      chk(dqm == ((k >= E_RDY) ? 8'h00 : 8'hff), "R7 dqm", dqm, (k >= E_RDY) ? 8'h00 : 8'hff);
      if (k == 1)
        chk(&dqm, "R1 first cycle", dqm, 8'hff);
      if (k == E_PRE) begin
        chk(addr[10] && ba == 2'b00, "R2 all-bank", {ba, addr}, 12'h400);
        if (restarted) chk(bus_code() == 1, "R9 restart", bus_code(), 1);
      end
      if (k == E_MRS) begin
        chk(addr == 12'(EXP_MODE), "R6 mode word", addr, EXP_MODE);
        chk(ba == 2'b00, "R6 bank", ba, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    do_reset(3);
    run_seq(E_RDY + 15, 1'b0);
    // directed cuts: just before precharge, exactly at mode set
    do_reset(2);
    run_seq(E_PRE - 1, 1'b1);
    do_reset(1);
    run_seq(E_MRS, 1'b1);
    // random cut points
    for (int t = 0; t < 6; t++) begin
      int stop_at, hold;
      stop_at = $urandom_range(E_RDY + 6, 1);
      hold    = $urandom_range(4, 1);
      do_reset(hold);
      run_seq(stop_at, 1'b1);
    end
    do_reset(2);
    run_seq(E_RDY + 10, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #4000000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule